// File: doc/BRIEF.md
# Margining Feedback-Divider Control

This block is the digital control side of a crystal-referenced clock synthesizer that supports frequency margining. A three-pin serial port (serial clock, serial data, load strobe) fills a 6-bit shift register. When the load strobe falls, the shift register is copied into a control register that holds the feedback divide value. A mode pin selects between two configurations. In nominal mode the block uses a fixed nominal setup: an undivided reference, feedback divide 25 and output divide 6. In margining mode it halves the reference and uses the programmed feedback value.

All serial and mode pins are treated as asynchronous. They are oversampled by a system clock through two-flop synchronizers, so the system clock must run at least several times faster than the serial clock. The block also reports when a programmed value would put the oscillator (12 MHz times M) outside its 540 to 680 MHz lock range. A 50% duty-cycle output divider, driven by a separate test clock, stands in for the analog output divider.

Top module: `smc_margin_ctl`

## Requirements
- R1: After reset, with mode low, `m_val` is 25, `pdiv_sel` is 0, `odiv_val` is 6 and `lock_risk` is 0; the control register resets to 50, so raising mode without any load gives `m_val` = 50.
- R2: While the synchronized load strobe is high, each synchronized rising edge of `ser_clk` shifts `ser_dat` into bit 0 of the shift register, so data enters MSB first and the first of six bits ends up as bit 5 of M.
- R3: A synchronized high-to-low transition of `ser_ld` copies the shift register into the control register; the control register changes at no other time.
- R4: While `ser_ld` is low, activity on `ser_clk` and `ser_dat` leaves the shift register unchanged, and a rising edge of `ser_ld` latches nothing.
- R5: With mode high, `m_val` equals the control register and `pdiv_sel` is 1 (reference divided by 2); with mode low, `m_val` is 25 and `pdiv_sel` is 0 whatever was latched.
- R6: Loads done while mode is low are kept and appear on `m_val` once mode goes high.
- R7: `lock_risk` is 1 exactly when mode is high and the control register is below 45 or above 56; the values 45 and 56 themselves do not raise it.
- R8: `odiv_val` is 6 in both modes.
- R9: `div_clk` toggles every 3 `tst_clk` cycles, giving a divide-by-6 clock that is high for 3 cycles and low for 3.
- R10: A change on `mode_hi` appears on the outputs at the second `clk` rising edge after it. A load strobe fall appears at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial and mode pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| tst_clk | input | 1 | Test clock feeding the output divider model |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first (asynchronous) |
| ser_ld | input | 1 | Load strobe; high enables shifting, falling edge latches |
| mode_hi | input | 1 | 1 = margining configuration, 0 = nominal configuration |
| m_val | output | 6 | Active feedback divide value |
| pdiv_sel | output | 1 | 1 = reference pre-divide by 2 |
| odiv_val | output | 4 | Output divide value |
| lock_risk | output | 1 | Programmed M outside the oscillator lock range while margining |
| div_clk | output | 1 | 50% duty-cycle divided test clock |

## Verification
The bench builds the block with its default parameters: 6-bit M, nominal value 25, reset value 50, lock window 45 to 56, output divide 6 and two synchronizer stages. With these values the directed loads reach both edges of the lock window from inside and outside, and the 25 versus 50 split separates nominal output from the reset contents of the control register. The two-stage synchronizer fixes the 2-edge and 3-edge latencies that the bench's per-clock model follows. The even divide of 6 lets the high and low phases be counted directly in test-clock cycles.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef struct packed {
    logic sclk;
    logic sdat;
    logic sld;
    logic mode;
  } smc_pins_t;
  localparam int PIN_W = $bits(smc_pins_t);
endpackage

// File: rtl/smc_rst_sync.sv
module smc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/smc_sync.sv
module smc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stg_d;
      if (g == 0) begin : g_first
        always_comb stg_d = d;
      end else begin : g_next
        always_comb stg_d = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/smc_shift_ctl.sv
module smc_shift_ctl #(
  parameter int M_W   = 6,
  parameter int RST_M = 50
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_s,
  input  logic           sdat_s,
  input  logic           sld_s,
  output logic [M_W-1:0] ctrl_q
);
  localparam logic [M_W-1:0] RST_V = (M_W)'(RST_M);

  logic           sclk_p, sld_p;
  logic           sclk_rise, shift_en, ld_fall;
  logic [M_W-1:0] shift_q, shift_d, ctrl_d;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_p;
    shift_en  = sclk_rise & sld_s;
    ld_fall   = sld_p & ~sld_s;
    shift_d   = shift_q;
    ctrl_d    = ctrl_q;
    if (shift_en) shift_d = {shift_q[M_W-2:0], sdat_s};
    if (ld_fall)  ctrl_d  = shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p  <= 1'b0;
      sld_p   <= 1'b0;
      shift_q <= '0;
      ctrl_q  <= RST_V;
    end else begin
      sclk_p <= sclk_s;
      sld_p  <= sld_s;
      if (shift_en) shift_q <= shift_d;
      if (ld_fall)  ctrl_q  <= ctrl_d;
    end
  end

  // R2: a qualified serial edge puts the sampled bit at the LSB
  assert_shift_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> shift_q[0] == $past(sdat_s));

  // R3: the control register moves only after a strobe fall
  assert_latch_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) |-> $past(ld_fall));

  // R4: with the strobe low the shift register holds
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sld_s && !$past(sld_s)) |-> $stable(shift_q));
endmodule

// File: rtl/smc_mode_sel.sv
module smc_mode_sel #(
  parameter int M_W     = 6,
  parameter int NOM_M   = 25,
  parameter int LOCK_LO = 45,
  parameter int LOCK_HI = 56
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_s,
  input  logic [M_W-1:0] ctrl,
  output logic [M_W-1:0] m_act,
  output logic           pdiv_sel,
  output logic           risk
);
  localparam logic [M_W-1:0] NOM_V = (M_W)'(NOM_M);
  localparam logic [M_W-1:0] LO_V  = (M_W)'(LOCK_LO);
  localparam logic [M_W-1:0] HI_V  = (M_W)'(LOCK_HI);

  logic out_of_win;

  always_comb begin
    out_of_win = (ctrl < LO_V) || (ctrl > HI_V);
    m_act      = mode_s ? ctrl : NOM_V;
    pdiv_sel   = mode_s;
    risk       = mode_s & out_of_win;
  end

  // R5: nominal mode always presents the fixed configuration
  assert_nominal_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |-> (m_act == NOM_V && !pdiv_sel));

  // R7: no lock warning inside the window
  assert_risk_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_act >= LO_V && m_act <= HI_V) |-> !risk);
endmodule

// File: rtl/smc_out_div.sv
module smc_out_div #(
  parameter int DIV = 6
) (
  input  logic tclk,
  input  logic rst_n,
  output logic div_q
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TERM = (CW)'(HALF - 1);

  logic          srst_n;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          div_d, wrap;

  smc_rst_sync #(.STAGES(2)) u_rst (.clk(tclk), .arst_n(rst_n), .srst_n(srst_n));

  always_comb begin
    wrap  = (cnt_q == TERM);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    div_d = wrap ? ~div_q : div_q;
  end

  always_ff @(posedge tclk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  // R9: independent run-length counter between output toggles
  logic [7:0] run_q;
  always_ff @(posedge tclk or negedge srst_n) begin
    if (!srst_n)                 run_q <= 8'd1;
    else if (div_d != div_q)     run_q <= 8'd1;
    else if (run_q != 8'hFF)     run_q <= run_q + 8'd1;
  end

  assert_half_period_R9: assert property (@(posedge tclk) disable iff (!srst_n)
    (div_q != $past(div_q)) |-> ($past(run_q) == 8'(HALF)));
endmodule

// File: rtl/smc_margin_ctl.sv
module smc_margin_ctl #(
  parameter int M_W     = 6,
  parameter int NOM_M   = 25,
  parameter int RST_M   = 50,
  parameter int LOCK_LO = 45,
  parameter int LOCK_HI = 56,
  parameter int ODIV    = 6,
  parameter int ODIV_W  = 4,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tst_clk,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_ld,
  input  logic              mode_hi,
  output logic [M_W-1:0]    m_val,
  output logic              pdiv_sel,
  output logic [ODIV_W-1:0] odiv_val,
  output logic              lock_risk,
  output logic              div_clk
);
  import smc_pkg::*;

  logic      srst_n;
  smc_pins_t pins_raw, pins_s;
  logic [M_W-1:0] ctrl;

  smc_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  always_comb begin
    pins_raw.sclk = ser_clk;
    pins_raw.sdat = ser_dat;
    pins_raw.sld  = ser_ld;
    pins_raw.mode = mode_hi;
  end

  smc_sync #(.W(PIN_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(srst_n), .d(pins_raw), .q(pins_s)
  );

  smc_shift_ctl #(.M_W(M_W), .RST_M(RST_M)) u_shift (
    .clk(clk), .rst_n(srst_n),
    .sclk_s(pins_s.sclk), .sdat_s(pins_s.sdat), .sld_s(pins_s.sld),
    .ctrl_q(ctrl)
  );

  smc_mode_sel #(.M_W(M_W), .NOM_M(NOM_M), .LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI)) u_mode (
    .clk(clk), .rst_n(srst_n), .mode_s(pins_s.mode), .ctrl(ctrl),
    .m_act(m_val), .pdiv_sel(pdiv_sel), .risk(lock_risk)
  );

  smc_out_div #(.DIV(ODIV)) u_odiv (.tclk(tst_clk), .rst_n(rst_n), .div_q(div_clk));

  assign odiv_val = (ODIV_W)'(ODIV);

  // R7: a lock warning only ever appears with the halved reference
  assert_risk_needs_margin_R7: assert property (@(posedge clk) disable iff (!srst_n)
    lock_risk |-> pdiv_sel);

  // R8: output divide is constant
  assert_odiv_const_R8: assert property (@(posedge clk) disable iff (!srst_n)
    $stable(odiv_val));
endmodule

// File: tb/smc_margin_ctl_tb.sv
module smc_margin_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TCK_PERIOD = 8;

  logic clk = 1'b0, tst_clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, mode_hi = 1'b0;
  logic [5:0] m_val;
  logic pdiv_sel, lock_risk, div_clk;
  logic [3:0] odiv_val;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(TCK_PERIOD/2) tst_clk = ~tst_clk;

  smc_margin_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .tst_clk(tst_clk),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld), .mode_hi(mode_hi),
    .m_val(m_val), .pdiv_sel(pdiv_sel), .odiv_val(odiv_val),
    .lock_risk(lock_risk), .div_clk(div_clk)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: pin history delayed by whole clocks
  bit c1, c2, c3, d1, d2, l1, l2, l3, o1, o2;
  int mshift, mctl;
  always @(posedge clk) begin
    if (!rst_n) begin
      {c1, c2, c3, d1, d2, l1, l2, l3, o1, o2} = '0;
      mshift = 0; mctl = 50;
    end else begin
      if (l2 && c2 && !c3) mshift = ((mshift << 1) | int'(d2)) & 63;
      if (l3 && !l2)       mctl = mshift;
      c3 = c2; c2 = c1; c1 = ser_clk;
      d2 = d1; d1 = ser_dat;
      l3 = l2; l2 = l1; l1 = ser_ld;
      o2 = o1; o1 = mode_hi;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 R10 m_val model", int'(m_val), o2 ? mctl : 25);
      chk("R5 pdiv_sel model", int'(pdiv_sel), int'(o2));
      chk("R7 lock_risk model", int'(lock_risk), int'(o2 && (mctl < 45 || mctl > 56)));
      chk("R8 odiv_val model", int'(odiv_val), 6);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_word(input logic [5:0] v);
    ser_ld = 1'b1; idle(3);
    for (int i = 5; i >= 0; i--) begin
      ser_dat = v[i]; idle(3);
      ser_clk = 1'b1; idle(3);
      ser_clk = 1'b0; idle(3);
    end
    ser_ld = 1'b0; idle(5);
  endtask

  task automatic set_mode(input logic v);
    mode_hi = v; idle(3);
  endtask

  task automatic duty_check();
    int run, level, seen;
    @(negedge tst_clk); level = div_clk; run = 0; seen = 0;
    while (seen < 7) begin
      @(negedge tst_clk);
      if (div_clk == level) run++;
      else begin
        if (seen > 0) chk(level ? "R9 high phase" : "R9 low phase", run + 1, 3);
        seen++; level = div_clk; run = 0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(4); rst_n = 1'b1; idle(6);
    // R1 reset state
    chk("R1 m_val", int'(m_val), 25);
    chk("R1 pdiv_sel", int'(pdiv_sel), 0);
    chk("R1 odiv_val", int'(odiv_val), 6);
    chk("R1 lock_risk", int'(lock_risk), 0);
    // R10 mode latency: still nominal after one edge, switched after two
    mode_hi = 1'b1; @(negedge clk);
    chk("R10 one edge", int'(m_val), 25);
    @(negedge clk);
    chk("R10 two edges", int'(m_val), 50);
    chk("R1 reset ctrl value", int'(m_val), 50);
    chk("R5 pdiv in margin", int'(pdiv_sel), 1);
    // R2 MSB first
    load_word(6'd32);
    chk("R2 msb first", int'(m_val), 32);
    chk("R7 low M flagged", int'(lock_risk), 1);
    load_word(6'b010110);
    chk("R2 pattern", int'(m_val), 22);
    // R7 window edges
    load_word(6'd44); chk("R7 m=44 risk", int'(lock_risk), 1);
    load_word(6'd45); chk("R7 m=45 risk", int'(lock_risk), 0);
    load_word(6'd56); chk("R7 m=56 risk", int'(lock_risk), 0);
    load_word(6'd57); chk("R7 m=57 risk", int'(lock_risk), 1);
    chk("R3 latched 57", int'(m_val), 57);
    // R4 activity with strobe low, then a bare strobe pulse
    for (int k = 0; k < 5; k++) begin
      ser_dat = k[0]; idle(2); ser_clk = 1'b1; idle(3); ser_clk = 1'b0; idle(3);
    end
    chk("R4 no change while low", int'(m_val), 57);
    ser_ld = 1'b1; idle(6);
    chk("R4 rising strobe no latch", int'(m_val), 57);
    ser_ld = 1'b0; idle(6);
    chk("R4 shift reg held", int'(m_val), 57);
    // R5 / R6 nominal mode
    set_mode(1'b0);
    chk("R5 nominal m", int'(m_val), 25);
    chk("R5 nominal risk", int'(lock_risk), 0);
    chk("R8 odiv nominal", int'(odiv_val), 6);
    load_word(6'd52);
    chk("R6 hidden while nominal", int'(m_val), 25);
    set_mode(1'b1);
    chk("R6 revealed", int'(m_val), 52);
    chk("R8 odiv margin", int'(odiv_val), 6);
    duty_check();
    idle(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule